// File: doc/BRIEF.md
# Packed Lane Integer Adder

This block adds or subtracts two 64-bit operands as a set of independent integer lanes. A two-bit size select splits the operands into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane gets the same operation in the same cycle, and no carry or borrow crosses between lanes.

A saturate enable picks how each lane handles overflow. With saturation off, each lane wraps modulo two to the power of its width. With saturation on, an unsigned add that overflows gives the lane's all-ones value, and an unsigned subtract that would go below zero gives zero. There are no carry or overflow flags at the ports; a clamped lane is the only sign that a limit was reached.

Operands are captured on a valid strobe. The result appears one clock later on a registered output, and an output valid goes high for that one cycle.

Top module: `packed_lane_adder`

## Requirements
- R1: sizeSel chooses the lane width: 2'b00 gives eight 8-bit lanes, 2'b01 four 16-bit lanes, 2'b10 two 32-bit lanes, 2'b11 one 64-bit lane. Lane k of width w occupies bits [k*w+w-1 : k*w] of the operands and of the result.
- R2: No carry or borrow passes from one lane into the next. Each lane's result depends only on the same bit positions of opA and opB.
- R3: With satEn=0 and opSub=0, each lane result is (a+b) mod 2^w.
- R4: With satEn=0 and opSub=1, each lane result is (a-b) mod 2^w.
- R5: With satEn=1 and opSub=0, a lane whose unsigned sum exceeds 2^w-1 gives 2^w-1 (for example 200+100 in a byte lane gives 255). Otherwise the lane gives the exact sum.
- R6: With satEn=1 and opSub=1, a lane where b > a gives 0. Otherwise the lane gives a-b.
- R7: opSub=0 selects addition and opSub=1 selects subtraction. All lanes perform the same operation.
- R8: When inValid is high at a rising edge, the operands are captured. outValid is high in the following cycle and shows the result for those operands. A cycle with inValid low is followed by a cycle with outValid low. Back-to-back valids give back-to-back results.
- R9: After a cycle with inValid low, result keeps its previous value.
- R10: A synchronous reset (rst high at a rising edge) clears outValid and result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Capture strobe for operands and mode |
| opA | input | 64 | First operand (minuend for subtract) |
| opB | input | 64 | Second operand (subtrahend for subtract) |
| sizeSel | input | 2 | Lane width: 00 byte, 01 16-bit, 10 32-bit, 11 64-bit |
| opSub | input | 1 | 0 = add, 1 = subtract |
| satEn | input | 1 | 1 = unsigned saturation, 0 = wrap |
| result | output | 64 | Registered packed result |
| outValid | output | 1 | High for one cycle when result is new |

## Verification
Two things can happen in the same cycle: a new operand set is captured while the previous result is on the output. The bench causes this by holding inValid high on consecutive edges with different modes and sizes. In each cycle it checks that outValid stays high and that result matches the operation captured one edge earlier, not the one being captured now.

Saturation and lane isolation can also act together in one lane. For example, an all-ones byte plus one, with saturation on, must clamp that byte and leave the neighbouring byte unchanged. The bench checks this against an arithmetic model that works lane by lane.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int SIZE_CNT = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_QUAD  = 2'b11
  } laneSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                load;
    logic [SIZE_CNT-1:0] sizeHot;
    logic                doSub;
    logic                doSat;
  } dpCtrl_t;
endpackage

// File: rtl/pla_lane.sv
module pla_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         doSub,
  input  logic         doSat,
  output logic [W-1:0] y
);
  logic [W:0] ext;

  always_comb begin
    if (doSub) ext = {1'b0, a} - {1'b0, b};
    else       ext = {1'b0, a} + {1'b0, b};
  end

  // ext[W]: carry out on add, borrow on subtract
  always_comb begin
    if (doSat && ext[W]) y = doSub ? '0 : '1;
    else                 y = ext[W-1:0];
  end
endmodule

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] sizeSel,
  input  logic       opSub,
  input  logic       satEn,
  output dpCtrl_t    ctrl,
  output logic       outValid
);
  always_comb begin
    ctrl.load    = inValid;
    ctrl.doSub   = opSub;
    ctrl.doSat   = satEn;
    ctrl.sizeHot = '0;
    unique case (laneSize_e'(sizeSel))
      SZ_BYTE:  ctrl.sizeHot[0] = 1'b1;
      SZ_WORD:  ctrl.sizeHot[1] = 1'b1;
      SZ_DWORD: ctrl.sizeHot[2] = 1'b1;
      SZ_QUAD:  ctrl.sizeHot[3] = 1'b1;
      default:  ctrl.sizeHot    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  logic [SIZE_CNT-1:0][DATA_W-1:0] laneOut;
  logic [DATA_W-1:0]               nextResult;

  for (genvar s = 0; s < SIZE_CNT; s++) begin : g_size
    localparam int W     = BASE_W << s;
    localparam int LANES = DATA_W / W;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      pla_lane #(.W(W)) u_lane (
        .a     (opA[k*W +: W]),
        .b     (opB[k*W +: W]),
        .doSub (ctrl.doSub),
        .doSat (ctrl.doSat),
        .y     (laneOut[s][k*W +: W])
      );
    end
  end

  // one-hot AND-OR select
  always_comb begin
    nextResult = '0;
    for (int s = 0; s < SIZE_CNT; s++) begin
      if (ctrl.sizeHot[s]) nextResult = nextResult | laneOut[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            result <= '0;
    else if (ctrl.load) result <= nextResult;
  end
endmodule

// File: rtl/packed_lane_adder.sv
module packed_lane_adder
  import pla_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        sizeSel,
  input  logic              opSub,
  input  logic              satEn,
  output logic [DATA_W-1:0] result,
  output logic              outValid
);
  dpCtrl_t ctrl;

  pla_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .sizeSel  (sizeSel),
    .opSub    (opSub),
    .satEn    (satEn),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  pla_datapath #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [1:0]        sizeSel,
  input logic              opSub,
  input logic              satEn,
  input logic [DATA_W-1:0] result,
  input logic              outValid
);
  p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

  p_quad_sat_add_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel == 2'b11 && !opSub && satEn) |=>
      (result >= $past(opA) && result >= $past(opB)));

  p_quad_sat_sub_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel == 2'b11 && opSub && satEn) |=> (result <= $past(opA)));

  p_byte0_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel == 2'b00 && !opSub && !satEn) |=>
      (result[7:0] == 8'($past(opA[7:0]) + $past(opB[7:0]))));
endmodule

bind packed_lane_adder pla_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .sizeSel  (sizeSel),
  .opSub    (opSub),
  .satEn    (satEn),
  .result   (result),
  .outValid (outValid)
);

// File: tb/tb_packed_lane_adder.sv
module tb_packed_lane_adder;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] opA, opB;
  logic [1:0]  sizeSel;
  logic        opSub, satEn;
  logic [63:0] result;
  logic        outValid;

  int checkCount = 0;
  int failCount  = 0;
  bit done       = 1'b0;

  always #10 clk = ~clk;

  packed_lane_adder dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .sizeSel(sizeSel), .opSub(opSub), .satEn(satEn),
    .result(result), .outValid(outValid)
  );

  function automatic logic [63:0] refCalc(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] sz, input logic sub, input logic sat);
    int w = 8 << sz;
    int n = 64 / w;
    logic [64:0] mask = (w == 64) ? {1'b0, {64{1'b1}}} : ((65'd1 << w) - 65'd1);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) begin
      logic [64:0] x = ({1'b0, a} >> (k * w)) & mask;
      logic [64:0] y = ({1'b0, b} >> (k * w)) & mask;
      logic [64:0] s;
      if (sub) begin
        s = x - y;
        if (x < y && sat) s = '0;
      end else begin
        s = x + y;
        if (s > mask && sat) s = mask;
      end
      s = s & mask;
      r = r | 64'(s << (k * w));
    end
    return r;
  endfunction

  function automatic string modeTag(input logic sub, input logic sat);
    if (sat) return sub ? "R6" : "R5";
    return sub ? "R4" : "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  // one operation, checked a cycle after capture
  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic sub, input logic sat, input string tag);
    @(negedge clk);
    opA = a; opB = b; sizeSel = sz; opSub = sub; satEn = sat; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " outValid R8"}, {63'd0, outValid}, 64'd1);
    check(tag, result, refCalc(a, b, sz, sub, sat));
  endtask

  logic [63:0] corners [8];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0; sizeSel = '0; opSub = 1'b0; satEn = 1'b0;
    corners[0] = 64'hFFFF_FFFF_FFFF_FFFF; corners[1] = 64'h0;
    corners[2] = 64'h0000_0000_0000_0001; corners[3] = 64'h8000_0000_0000_0000;
    corners[4] = 64'h7F7F_7F7F_7F7F_7F7F; corners[5] = 64'h0101_0101_0101_0101;
    corners[6] = 64'h00FF_00FF_00FF_00FF; corners[7] = 64'hFFFF_0000_FFFF_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset outValid", {63'd0, outValid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    rst = 1'b0;

    // directed corners
    runOp(64'h00FF, 64'h0001, 2'b00, 1'b0, 1'b0, "R2 byte wrap isolates");
    check("R2 byte FF+1 wrap", result, 64'h0);
    runOp(64'h00FF, 64'h0001, 2'b00, 1'b0, 1'b1, "R5 byte FF+1 sat");
    check("R5 byte FF+1 sat", result, 64'hFF);
    runOp(64'd200, 64'd100, 2'b00, 1'b0, 1'b1, "R5 200+100");
    check("R5 200+100", result, 64'd255);
    runOp(64'h00FF, 64'h0001, 2'b01, 1'b0, 1'b0, "R1 word carry");
    check("R1 word carry inside lane", result, 64'h0100);
    runOp(64'h0000_0000_FFFF_FFFF, 64'h1, 2'b10, 1'b0, 1'b0, "R1 dword");
    check("R1 dword lane cut", result, 64'h0);
    runOp(64'h0000_0000_FFFF_FFFF, 64'h1, 2'b11, 1'b0, 1'b0, "R1 quad");
    check("R1 quad carry", result, 64'h1_0000_0000);
    runOp(64'h0100, 64'h0001, 2'b00, 1'b1, 1'b0, "R2 byte borrow");
    check("R2 byte borrow isolated", result, 64'h01FF);
    runOp(64'h0100, 64'h0001, 2'b00, 1'b1, 1'b1, "R6 byte sub sat");
    check("R6 byte sub clamps", result, 64'h0100);
    runOp(64'h5, 64'h3, 2'b11, 1'b1, 1'b0, "R7 sub select");
    check("R7 opSub=1 subtracts", result, 64'h2);
    runOp(64'h5, 64'h3, 2'b11, 1'b0, 1'b0, "R7 add select");
    check("R7 opSub=0 adds", result, 64'h8);

    // R9 hold and R8 idle
    @(negedge clk);
    opA = 64'h1234; opB = 64'h4321; sizeSel = 2'b01; opSub = 1'b1;
    @(negedge clk);
    check("R8 idle outValid", {63'd0, outValid}, 64'd0);
    check("R9 result held", result, 64'h8);

    // back-to-back captures
    @(negedge clk);
    opA = 64'hFF; opB = 64'h02; sizeSel = 2'b00; opSub = 1'b0; satEn = 1'b1; inValid = 1'b1;
    @(negedge clk);
    check("R8 b2b first valid", {63'd0, outValid}, 64'd1);
    check("R8 b2b first", result, 64'hFF);
    opA = 64'h10; opB = 64'h20; sizeSel = 2'b11; opSub = 1'b1; satEn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R8 b2b second valid", {63'd0, outValid}, 64'd1);
    check("R8 b2b second", result, 64'hFFFF_FFFF_FFFF_FFF0);
    @(negedge clk);
    check("R8 single pulse", {63'd0, outValid}, 64'd0);

    // corner sweep across all sizes and modes
    for (int sz = 0; sz < 4; sz++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            runOp(corners[i], corners[j], 2'(sz), m[1], m[0],
                  $sformatf("%s size%0d", modeTag(m[1], m[0]), sz));

    // byte-lane value sweep, each lane different
    for (int m = 0; m < 4; m++)
      for (int av = 0; av < 256; av += 15)
        for (int bv = 0; bv < 256; bv += 15) begin
          logic [63:0] a, b;
          for (int k = 0; k < 8; k++) begin
            a[k*8 +: 8] = 8'(av + k * 37);
            b[k*8 +: 8] = 8'(bv + k * 59);
          end
          runOp(a, b, 2'b00, m[1], m[0], {modeTag(m[1], m[0]), " byte sweep"});
        end

    // reset mid-stream
    runOp(64'h77, 64'h11, 2'b00, 1'b0, 1'b0, "R3 pre-reset");
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    check("R10 reset clears result", result, 64'h0);
    check("R10 reset clears outValid", {63'd0, outValid}, 64'd0);

    done = 1'b1;
    summary();
  end
endmodule